// File: doc/BRIEF.md
# Two-Parallel Negacyclic Polynomial Multiplier

This block multiplies two polynomials of length n in the ring of integer polynomials modulo x^n+1. Every coefficient is reduced modulo a small prime q. A host first writes both operands into internal storage, one coefficient at a time. It then pulses a start input. The block sorts each operand by coefficient parity into an even half and an odd half. It forms three half-length products: even by even, odd by odd, and sum by sum. Each product is computed negacyclically modulo y^(n/2)+1, where y = x^2.

All three products run in turn on one shared iterative multiply-accumulate core. The core performs one coefficient multiply per cycle. While the result streams out, the block rebuilds the full-length product from the three stored half products. The even-index outputs combine the first two products, with the odd-by-odd term shifted one place and wrapped with a sign flip. The odd-index outputs subtract the first two products from the sum-by-sum product.

Top module: `poly_mul_nc2`

## Requirements
- R1: After a run, the streamed coefficients equal the product of operand A and operand B modulo x^n+1, with each coefficient reduced into 0..q-1. This assumes every loaded coefficient is already in 0..q-1.
- R2: When `load_we` is high, `load_data` is written to coefficient `load_idx` of operand A if `load_sel` is 0, and of operand B if `load_sel` is 1. A write that arrives while `busy` is high is ignored.
- R3: `start` is accepted only while `busy` is low. A `start` pulse raised during a run or during the readout has no effect.
- R4: The first result coefficient appears with `res_valid` high exactly 3*(n/2)^2+1 cycles after the clock edge that accepts `start`. The following n consecutive cycles carry coefficients 0 through n-1 in ascending order.
- R5: `done` is high for exactly one cycle, the cycle that carries coefficient n-1.
- R6: `busy` rises on the edge that accepts `start` and falls together with the last coefficient.
- R7: Terms of degree n or more wrap with a negated sign. For example, x^(n-1) times x^(n-1) yields coefficient n-2 equal to q-1 and every other coefficient equal to 0.
- R8: Operands whose coefficients are all q-1 give the exact reduced product. This exercises every modular correction at its largest inputs.
- R9: After reset, `busy`, `res_valid` and `done` are low.
- R10: The operands are kept across runs. A second `start` with no new loads gives the same result again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Operand coefficient write strobe |
| load_sel | input | 1 | Operand select: 0 for A, 1 for B |
| load_idx | input | log2(N) | Coefficient index being written |
| load_data | input | CW | Coefficient value, in 0..q-1 |
| start | input | 1 | Start pulse |
| busy | output | 1 | A run or its readout is in progress |
| res_valid | output | 1 | `res_data` holds a result coefficient |
| res_data | output | CW | Result coefficient, lowest index first |
| done | output | 1 | Marks the final result coefficient |

## Verification
Two kinds of host activity can land in the same cycle as the block's own work. An operand write can coincide with an active run. A new `start` can coincide with a run or with the result readout. The bench raises a write to operand A together with a `start` a few cycles into a run. It raises a second `start` partway through the readout. It then judges the outcome in two ways. Every streamed coefficient must still match the negacyclic schoolbook model of the operands held before the intrusion. `busy` must stay low once the stream ends, which shows that neither intrusion was taken up.

// File: rtl/pmm_pkg.sv
// Shared types for the two-parallel negacyclic multiplier.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package pmm_pkg;
    // Sub-product being formed on the shared core, in run order.
    typedef enum logic [1:0] {PH_EVEN = 2'd0, PH_ODD = 2'd1, PH_SUM = 2'd2} phase_e;
    // Top-level control state.
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_READ = 2'd2} ctrl_e;
endpackage

// File: rtl/pmm_mulmod.sv
// Combinational modular multiplier: r = a*b mod Q.
// Assumes: a and b are already below Q.
module pmm_mulmod #(
    parameter int Q  = 3329,
    parameter int CW = 12
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic [CW-1:0] r
);
    localparam int PW = 2 * CW;
    logic [PW-1:0] prod;

    // Full-width product, then remainder by the constant modulus.
    assign prod = {{CW{1'b0}}, a} * {{CW{1'b0}}, b};
    assign r    = CW'(prod % PW'(Q));
endmodule

// File: rtl/pmm_core.sv
// Shared iterative negacyclic schoolbook core at half length H.
// It steps phases EVEN, ODD, SUM. Within each phase it walks i (outer)
// and j (inner) over 0..H-1, one multiply-accumulate per cycle. The
// accumulator storage lives in the parent, which supplies the old value
// at wr_addr. Row i=0 overwrites, so no clearing pass is needed.
// Assumes: H is a power of two; operands and the old value are below Q.
module pmm_core #(
    parameter int Q  = 3329,
    parameter int CW = 12,
    parameter int H  = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CW-1:0]           op_a,
    input  logic [CW-1:0]           op_b,
    input  logic [CW-1:0]           acc_old,
    output logic                    active,
    output pmm_pkg::phase_e         phase,
    output logic [$clog2(H)-1:0]    idx_i,
    output logic [$clog2(H)-1:0]    idx_j,
    output logic [$clog2(H)-1:0]    wr_addr,
    output logic [CW-1:0]           wr_data,
    output logic                    last
);
    import pmm_pkg::*;
    localparam int HW = $clog2(H);
    localparam logic [HW-1:0] IMAX = HW'(H - 1);

    logic [HW:0]   ksum;
    logic          wrap;
    logic [CW-1:0] prod;

    function automatic logic [CW-1:0] madd(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (CW+1)'(Q)) s = s - (CW+1)'(Q);
        return s[CW-1:0];
    endfunction

    function automatic logic [CW-1:0] msub(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] d;
        if (a >= b) d = {1'b0, a} - {1'b0, b};
        else        d = {1'b0, a} + (CW+1)'(Q) - {1'b0, b};
        return d[CW-1:0];
    endfunction

    pmm_mulmod #(.Q(Q), .CW(CW)) u_mul (.a(op_a), .b(op_b), .r(prod));

    // Target index i+j; its top bit tells a wrap past y^H.
    assign ksum    = {1'b0, idx_i} + {1'b0, idx_j};
    assign wrap    = ksum[HW];
    assign wr_addr = ksum[HW-1:0];
    assign last    = active && (phase == PH_SUM) && (idx_i == IMAX) && (idx_j == IMAX);

    // New accumulator value: overwrite on row 0, subtract on wrap, else add.
    always_comb begin
        if (idx_i == '0) wr_data = prod;
        else if (wrap)   wr_data = msub(acc_old, prod);
        else             wr_data = madd(acc_old, prod);
    end

    // Loop counters and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= PH_EVEN;
            idx_i  <= '0;
            idx_j  <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                phase  <= PH_EVEN;
                idx_i  <= '0;
                idx_j  <= '0;
            end
        end else begin
            idx_j <= idx_j + 1'b1;
            if (idx_j == IMAX) begin
                idx_i <= idx_i + 1'b1;
                if (idx_i == IMAX) begin
                    case (phase)
                        PH_EVEN: phase <= PH_ODD;
                        PH_ODD:  phase <= PH_SUM;
                        default: begin
                            phase  <= PH_EVEN;
                            active <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/poly_mul_nc2.sv
// Two-parallel negacyclic polynomial multiplier, modulo x^N+1 and Q.
// It holds operands A and B and three half-length product stores. It
// sequences the shared core and interpolates during readout:
//   out[2t]   = P0[t] + P1[t-1]   (t=0: P0[0] - P1[H-1])
//   out[2t+1] = P2[t] - P0[t] - P1[t]
// Assumes: N is a power of two, at least 4; loaded coefficients are below Q.
module poly_mul_nc2 #(
    parameter int N  = 256,
    parameter int Q  = 3329,
    parameter int CW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_we,
    input  logic                    load_sel,
    input  logic [$clog2(N)-1:0]    load_idx,
    input  logic [CW-1:0]           load_data,
    input  logic                    start,
    output logic                    busy,
    output logic                    res_valid,
    output logic [CW-1:0]           res_data,
    output logic                    done
);
    import pmm_pkg::*;
    localparam int H  = N / 2;
    localparam int AW = $clog2(N);
    localparam int HW = $clog2(H);

    logic [CW-1:0] mem_a [N];
    logic [CW-1:0] mem_b [N];
    logic [CW-1:0] p_even [H];
    logic [CW-1:0] p_odd  [H];
    logic [CW-1:0] p_sum  [H];

    ctrl_e          state;
    logic [AW-1:0]  rd_idx;
    logic           core_act, core_last;
    phase_e         core_ph;
    logic [HW-1:0]  ci, cj, waddr, rt;
    logic [CW-1:0]  opa, opb, accv, wdata, interp;
    logic [AW-1:0]  ea, oa, eb, ob;

    function automatic logic [CW-1:0] madd(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= (CW+1)'(Q)) s = s - (CW+1)'(Q);
        return s[CW-1:0];
    endfunction

    function automatic logic [CW-1:0] msub(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] d;
        if (a >= b) d = {1'b0, a} - {1'b0, b};
        else        d = {1'b0, a} + (CW+1)'(Q) - {1'b0, b};
        return d[CW-1:0];
    endfunction

    assign busy = (state != ST_IDLE);

    pmm_core #(.Q(Q), .CW(CW), .H(H)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start && (state == ST_IDLE)),
        .op_a(opa), .op_b(opb), .acc_old(accv),
        .active(core_act), .phase(core_ph), .idx_i(ci), .idx_j(cj),
        .wr_addr(waddr), .wr_data(wdata), .last(core_last)
    );

    // Operand addresses of the even and odd halves.
    assign ea = {ci, 1'b0};
    assign oa = {ci, 1'b1};
    assign eb = {cj, 1'b0};
    assign ob = {cj, 1'b1};

    // Feed the core with the half operands and the old value for this phase.
    always_comb begin
        case (core_ph)
            PH_EVEN: begin opa = mem_a[ea]; opb = mem_b[eb]; accv = p_even[waddr]; end
            PH_ODD:  begin opa = mem_a[oa]; opb = mem_b[ob]; accv = p_odd[waddr];  end
            default: begin
                opa  = madd(mem_a[ea], mem_a[oa]);
                opb  = madd(mem_b[eb], mem_b[ob]);
                accv = p_sum[waddr];
            end
        endcase
    end

    // Operand storage writes, blocked while busy.
    always_ff @(posedge clk) begin
        if (load_we && !busy) begin
            if (load_sel) mem_b[load_idx] <= load_data;
            else          mem_a[load_idx] <= load_data;
        end
    end

    // Store the core result into the store of the current phase.
    always_ff @(posedge clk) begin
        if (core_act) begin
            case (core_ph)
                PH_EVEN: p_even[waddr] <= wdata;
                PH_ODD:  p_odd[waddr]  <= wdata;
                default: p_sum[waddr]  <= wdata;
            endcase
        end
    end

    // Interpolate the coefficient at rd_idx from the three products.
    assign rt = rd_idx[AW-1:1];
    always_comb begin
        if (rd_idx[0])      interp = msub(msub(p_sum[rt], p_even[rt]), p_odd[rt]);
        else if (rt == '0)  interp = msub(p_even[0], p_odd[H-1]);
        else                interp = madd(p_even[rt], p_odd[rt - 1'b1]);
    end

    // Control: accept start, wait for the core, stream N coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rd_idx    <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            done      <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: if (start) state <= ST_RUN;
                ST_RUN: if (core_last) begin
                    state  <= ST_READ;
                    rd_idx <= '0;
                end
                default: begin
                    res_valid <= 1'b1;
                    res_data  <= interp;
                    rd_idx    <= rd_idx + 1'b1;
                    if (rd_idx == AW'(N - 1)) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pmm_checker.sv
// Port-level protocol checks for poly_mul_nc2, attached by bind.
// Assumes: synchronous active-low reset; checks are off while reset is low.
module pmm_checker #(
    parameter int Q  = 3329,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          res_valid,
    input logic [CW-1:0] res_data,
    input logic          done
);
    assert_coef_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data < CW'(Q)));

    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !res_valid) |=> busy);

    assert_valid_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !done) |-> busy);

    assert_done_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind poly_mul_nc2 pmm_checker #(.Q(Q), .CW(CW)) u_pmm_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .res_valid(res_valid), .res_data(res_data), .done(done)
);

// File: tb/test_poly_mul_nc2.sv
// Bench: a behavioural negacyclic schoolbook model plus a per-cycle
// expectation of busy, res_valid, done and res_data.
module test_poly_mul_nc2;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 32;
    localparam int Q   = 3329;
    localparam int CW  = 12;
    localparam int H   = N / 2;
    localparam int LAT = 3 * H * H + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_we = 1'b0, load_sel = 1'b0, start = 1'b0;
    logic [$clog2(N)-1:0] load_idx = '0;
    logic [CW-1:0] load_data = '0;
    logic busy, res_valid, done;
    logic [CW-1:0] res_data;

    int checks = 0, errors = 0;
    int va[N], vb[N], vexp[N];
    bit finished = 0;

    poly_mul_nc2 #(.N(N), .Q(Q), .CW(CW)) i_poly_mul_nc2 (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_sel(load_sel),
        .load_idx(load_idx), .load_data(load_data), .start(start),
        .busy(busy), .res_valid(res_valid), .res_data(res_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Direct negacyclic schoolbook product of va and vb.
    task automatic model();
        for (int k = 0; k < N; k++) vexp[k] = 0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                int p = (va[i] * vb[j]) % Q;
                if (i + j < N) vexp[i+j] = (vexp[i+j] + p) % Q;
                else           vexp[i+j-N] = (vexp[i+j-N] + Q - p) % Q;
            end
    endtask

    // R2: write both operands through the load port.
    task automatic load_all();
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < N; k++) begin
                @(negedge clk);
                load_we = 1'b1; load_sel = s[0]; load_idx = k[$clog2(N)-1:0];
                load_data = (s == 0) ? va[k][CW-1:0] : vb[k][CW-1:0];
            end
        @(negedge clk);
        load_we = 1'b0;
    endtask

    // Run once and compare every cycle; optionally intrude with a write and starts.
    task automatic run(input string tag, input bit intrude);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check({tag, " R6 busy after start"}, busy, 1);
        for (int c = 1; c <= LAT + N + 3; c++) begin
            if (intrude && c == 5) begin
                load_we = 1'b1; load_sel = 1'b0; load_idx = '0; load_data = 12'd123; start = 1'b1;
            end
            if (intrude && c == LAT + 2) start = 1'b1;
            @(negedge clk);
            load_we = 1'b0; start = 1'b0;
            check({tag, " R4 res_valid"}, res_valid, (c >= LAT && c < LAT + N) ? 1 : 0);
            check({tag, " R5 done"}, done, (c == LAT + N - 1) ? 1 : 0);
            check({tag, " R6/R3 busy"}, busy, (c < LAT + N - 1) ? 1 : 0);
            if (c >= LAT && c < LAT + N)
                check($sformatf("%s R1 coef %0d", tag, c - LAT), res_data, vexp[c-LAT]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 busy at reset", busy, 0);
        check("R9 res_valid at reset", res_valid, 0);
        check("R9 done at reset", done, 0);

        // R1: random operands, with intrusion during the run (R2, R3).
        for (int k = 0; k < N; k++) begin va[k] = $urandom % Q; vb[k] = $urandom % Q; end
        model();
        load_all();
        run("random", 1'b1);
        // R10: operands kept; the intruding write must not have landed.
        run("rerun R10", 1'b0);

        // R8: all coefficients q-1.
        for (int k = 0; k < N; k++) begin va[k] = Q - 1; vb[k] = Q - 1; end
        model();
        load_all();
        run("all-max R8", 1'b0);

        // R7: x^(N-1) squared wraps to -x^(N-2).
        for (int k = 0; k < N; k++) begin va[k] = 0; vb[k] = 0; end
        va[N-1] = 1; vb[N-1] = 1;
        model();
        check("R7 model wrap", vexp[N-2], Q - 1);
        load_all();
        run("wrap R7", 1'b0);

        // Second random pattern, sparse operand B.
        for (int k = 0; k < N; k++) begin va[k] = $urandom % Q; vb[k] = (k % 5 == 0) ? $urandom % Q : 0; end
        model();
        load_all();
        run("sparse", 1'b1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule